// File: doc/BRIEF.md
# SDRAM refresh and power-down sequencer

This block is the control half of an SDRAM bus controller. It decides when the memory receives refresh commands. It decides when the memory is put into self-refresh. It also decides when clock enable is dropped to park the device in power-down. Read and write traffic, addressing and the pads belong to other blocks.

Four configuration bits select the behaviour:

- a half-cycle hold option;
- refresh on or off;
- auto-refresh or self-refresh;
- power-down on or off.

A compare value sets the auto-refresh interval. A bus-side indication tells the sequencer whether an access is running, whether it targets SDRAM, and when it ends.

The outputs are:

- the four SDRAM command pins;
- clock enable;
- a ready flag that grants the command slot to SDRAM accesses;
- two edge selects that tell the I/O stage whether to launch and capture on the falling edge.

Top module: `sdram_pwr_seq`

## Requirements
- R1: While cfg_ref_en is 0, the command pins {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} never show refresh (4'b0001) or precharge-all (4'b0010). Idle is shown as NOP (4'b0111).
- R2: When cfg_ref_en and cfg_ref_self are both 1 and no SDRAM access is active, the block issues three things in consecutive cycles. The first cycle shows precharge-all with sd_cke high. The next cycle shows refresh with sd_cke low. After that, NOP is shown with sd_cke low for as long as both bits stay 1.
- R3: With cfg_ref_en=1 and cfg_ref_self=0, a refresh counter runs from zero. A refresh command is issued every ref_cmp+1 cycles when nothing blocks it. This holds for ref_cmp greater than REF_GAP (default 3).
- R4: With cfg_pd_en=1 and the block idle, sd_cke and sd_ready are low in the cycle after bus_end is seen with bus_sdram=0. The end of an SDRAM access does not trigger power-down.
- R5: With cfg_pd_en=0, sd_cke stays high after accesses to other memory end.
- R6: launch_fall and capture_fall each equal the value that cfg_halfcyc_hold had one cycle earlier. The value 1 means the falling edge.
- R7: After reset, sd_cke=1, the command is NOP, sd_ready=1, and both edge selects are 0.
- R8: In power-down, two events wake the device: an SDRAM request (bus_act and bus_sdram both 1), or clearing cfg_pd_en. After either one, sd_cke is high in the next cycle with sd_ready still low, and sd_ready rises one cycle later.
- R9: In self-refresh, clearing cfg_ref_self or cfg_ref_en raises sd_cke in the next cycle. sd_ready then stays low for exactly EXIT_CYC cycles (default 4) before it goes high.
- R10: A pending auto-refresh is not issued while bus_act and bus_sdram are both 1. It is issued in the first cycle after that condition clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_halfcyc_hold | input | 1 | 1 selects falling-edge launch and capture |
| cfg_ref_en | input | 1 | Refresh enable |
| cfg_ref_self | input | 1 | 1 selects self-refresh, 0 selects auto-refresh |
| cfg_pd_en | input | 1 | Power-down after a non-SDRAM access |
| ref_cmp | input | CNT_W | Auto-refresh compare value |
| bus_act | input | 1 | A bus access is in progress |
| bus_sdram | input | 1 | The current access targets SDRAM |
| bus_end | input | 1 | Last cycle of the current access |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_ready | output | 1 | SDRAM command slot free for accesses |
| launch_fall | output | 1 | Launch commands and write data on the falling edge |
| capture_fall | output | 1 | Capture read data on the falling edge |

## Verification
The assertions take three things for granted about the inputs:

- bus_end occurs only while bus_act is high;
- ref_cmp is changed only while the refresh timer is stopped;
- ref_cmp exceeds the post-refresh recovery gap.

The stimulus respects all three. It clears cfg_ref_en for some cycles before every new compare value, and it uses compare values of eight or more.

The random phase disables refresh and holds bus_sdram low. As a result, only the power-down triggers and the edge select change, and a small bench model can predict clock enable and ready in every cycle.

// File: rtl/sdrseq_pkg.sv
package sdrseq_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP  = 4'b0111,
    CMD_PALL = 4'b0010,
    CMD_REF  = 4'b0001
  } sd_cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PALL,
    ST_SENTER,
    ST_SELF,
    ST_SEXIT,
    ST_AREF,
    ST_RWAIT,
    ST_SLEEP,
    ST_WAKE
  } seq_st_e;

endpackage

// File: rtl/sdrseq_rst_sync.sv
module sdrseq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/sdrseq_ref_timer.sv
module sdrseq_ref_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] cmp,
  input  logic             ack,
  output logic             pend
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             hit;

  always_comb begin
    hit = run && (cnt_q == cmp);
    if (!run)     cnt_d = '0;
    else if (hit) cnt_d = '0;
    else          cnt_d = cnt_q + 1'b1;

    if (!run)     pend_d = 1'b0;
    else if (hit) pend_d = 1'b1;
    else if (ack) pend_d = 1'b0;
    else          pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

  // R3: a compare match leaves a refresh pending
  a_r3_match_pends: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_q == cmp) |=> pend);

  // R1: stopping the timer drops any pending refresh and restarts from zero
  a_r1_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!pend && cnt_q == '0));

endmodule

// File: rtl/sdrseq_fsm.sv
module sdrseq_fsm
  import sdrseq_pkg::*;
#(
  parameter int EXIT_CYC = 4,
  parameter int REF_GAP  = 3
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ref_en,
  input  logic    ref_self,
  input  logic    pd_en,
  input  logic    pend,
  input  logic    bus_act,
  input  logic    bus_sdram,
  input  logic    bus_end,
  output sd_cmd_e cmd,
  output logic    cke,
  output logic    ready,
  output logic    ref_ack
);

  localparam int WMAX   = (EXIT_CYC > REF_GAP) ? EXIT_CYC : REF_GAP;
  localparam int WCNT_W = (WMAX < 2) ? 1 : $clog2(WMAX);

  seq_st_e           st_q, st_d;
  logic [WCNT_W-1:0] wait_q, wait_ld_val;
  logic              wait_ld, wait_dec;
  logic              sdr_busy, sref_req, auto_req, pd_trig;

  assign sdr_busy = bus_act && bus_sdram;
  assign sref_req = ref_en && ref_self;
  assign auto_req = ref_en && !ref_self && pend;
  assign pd_trig  = pd_en && bus_end && !bus_sdram;

  always_comb begin
    st_d        = st_q;
    wait_ld     = 1'b0;
    wait_dec    = 1'b0;
    wait_ld_val = '0;
    case (st_q)
      ST_IDLE: begin
        if (!sdr_busy) begin
          if (sref_req)      st_d = ST_PALL;
          else if (auto_req) st_d = ST_AREF;
          else if (pd_trig)  st_d = ST_SLEEP;
        end
      end
      ST_PALL:   st_d = sref_req ? ST_SENTER : ST_IDLE;
      ST_SENTER: st_d = ST_SELF;
      ST_SELF: begin
        if (!sref_req) begin
          st_d        = ST_SEXIT;
          wait_ld     = 1'b1;
          wait_ld_val = WCNT_W'(EXIT_CYC - 1);
        end
      end
      ST_SEXIT, ST_RWAIT: begin
        if (wait_q == '0) st_d = ST_IDLE;
        else              wait_dec = 1'b1;
      end
      ST_AREF: begin
        st_d        = ST_RWAIT;
        wait_ld     = 1'b1;
        wait_ld_val = WCNT_W'(REF_GAP - 1);
      end
      ST_SLEEP: begin
        if (sdr_busy || sref_req || auto_req || !pd_en) st_d = ST_WAKE;
      end
      ST_WAKE:   st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wait_q <= '0;
    end else begin
      st_q <= st_d;
      if (wait_ld)       wait_q <= wait_ld_val;
      else if (wait_dec) wait_q <= wait_q - 1'b1;
    end
  end

  always_comb begin
    case (st_q)
      ST_PALL:            cmd = CMD_PALL;
      ST_SENTER, ST_AREF: cmd = CMD_REF;
      default:            cmd = CMD_NOP;
    endcase
    cke     = !(st_q == ST_SENTER || st_q == ST_SELF || st_q == ST_SLEEP);
    ready   = (st_q == ST_IDLE);
    ref_ack = (st_q == ST_AREF);
  end

  // R1: refresh and precharge commands only follow an enabled refresh bit
  a_r1_cmd_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_REF || cmd == CMD_PALL) |-> $past(ref_en));

  // R2: self-refresh entry is always preceded by precharge-all
  a_r2_entry_after_pall: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SENTER) |-> $past(st_q == ST_PALL));

  // R4: power-down is entered only on a finished non-SDRAM access
  a_r4_sleep_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SLEEP && $past(st_q) != ST_SLEEP) |-> $past(pd_en && bus_end && !bus_sdram));

  // R8: leaving power-down always passes through the wake cycle
  a_r8_wake_path: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q == ST_SLEEP) && st_q != ST_SLEEP) |-> (st_q == ST_WAKE));

  // R9: self-refresh is left only after its request went away
  a_r9_exit_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q == ST_SELF) && st_q != ST_SELF) |-> $past(!(ref_en && ref_self)));

  // R10: auto-refresh never cuts into an SDRAM access
  a_r10_no_ref_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_AREF) |-> $past(!(bus_act && bus_sdram)));

endmodule

// File: rtl/sdram_pwr_seq.sv
module sdram_pwr_seq
  import sdrseq_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int EXIT_CYC = 4,
  parameter int REF_GAP  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_halfcyc_hold,
  input  logic             cfg_ref_en,
  input  logic             cfg_ref_self,
  input  logic             cfg_pd_en,
  input  logic [CNT_W-1:0] ref_cmp,
  input  logic             bus_act,
  input  logic             bus_sdram,
  input  logic             bus_end,
  output logic             sd_cs_n,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             sd_we_n,
  output logic             sd_cke,
  output logic             sd_ready,
  output logic             launch_fall,
  output logic             capture_fall
);

  logic    rst_n_i;
  logic    pend, ref_ack, timer_run;
  sd_cmd_e cmd;
  logic    edge_q;

  sdrseq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  assign timer_run = cfg_ref_en && !cfg_ref_self;

  sdrseq_ref_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n_i),
    .run   (timer_run),
    .cmp   (ref_cmp),
    .ack   (ref_ack),
    .pend  (pend)
  );

  sdrseq_fsm #(.EXIT_CYC(EXIT_CYC), .REF_GAP(REF_GAP)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .ref_en    (cfg_ref_en),
    .ref_self  (cfg_ref_self),
    .pd_en     (cfg_pd_en),
    .pend      (pend),
    .bus_act   (bus_act),
    .bus_sdram (bus_sdram),
    .bus_end   (bus_end),
    .cmd       (cmd),
    .cke       (sd_cke),
    .ready     (sd_ready),
    .ref_ack   (ref_ack)
  );

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) edge_q <= 1'b0;
    else          edge_q <= cfg_halfcyc_hold;
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign launch_fall  = edge_q;
  assign capture_fall = edge_q;

  // R7/R2: clock enable is low only while the command slot is closed
  a_r7_cke_low_not_ready: assert property (@(posedge clk) disable iff (!rst_n_i)
    !sd_cke |-> !sd_ready);

endmodule

// File: tb/sdram_pwr_seq_test.sv
module sdram_pwr_seq_test;

  localparam int CNT_W = 10;
  localparam int EXIT_CYC = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_halfcyc_hold, cfg_ref_en, cfg_ref_self, cfg_pd_en;
  logic [CNT_W-1:0] ref_cmp;
  logic bus_act, bus_sdram, bus_end;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke, sd_ready, launch_fall, capture_fall;

  int errs = 0;
  int checks = 0;

  always #4 clk = ~clk;

  sdram_pwr_seq #(.CNT_W(CNT_W), .EXIT_CYC(EXIT_CYC), .REF_GAP(3)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_halfcyc_hold(cfg_halfcyc_hold),
    .cfg_ref_en(cfg_ref_en), .cfg_ref_self(cfg_ref_self), .cfg_pd_en(cfg_pd_en),
    .ref_cmp(ref_cmp), .bus_act(bus_act), .bus_sdram(bus_sdram), .bus_end(bus_end),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_cke(sd_cke), .sd_ready(sd_ready), .launch_fall(launch_fall), .capture_fall(capture_fall)
  );

  function automatic logic [3:0] cmd_now();
    return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  endfunction

  // bench model for the random phase: 0 idle, 1 power-down, 2 wake
  function automatic int pd_next(int m, logic pd, logic fin);
    case (m)
      0: return (pd && fin) ? 1 : 0;
      1: return pd ? 1 : 2;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic ref_gaps(input int cmpv, input int ncyc);
    int last = -1;
    int nref = 0;
    ref_cmp = CNT_W'(cmpv);
    cfg_ref_en = 1'b1;
    for (int i = 0; i < ncyc; i++) begin
      cyc();
      if (cmd_now() == 4'b0001) begin
        if (last >= 0) chk(i - last == cmpv + 1, "R3 refresh interval", i - last, cmpv + 1);
        last = i;
        nref++;
      end
    end
    chk(nref >= 3, "R3 refresh count", nref, 3);
    cfg_ref_en = 1'b0;
    repeat (8) cyc();
  endtask

  task automatic self_exit(input bit by_enable);
    int n = 0;
    cfg_ref_en = 1'b1; cfg_ref_self = 1'b1; ref_cmp = CNT_W'(20);
    cyc();
    chk(cmd_now() == 4'b0010 && sd_cke, "R2 precharge-all first", cmd_now(), 4'b0010);
    cyc();
    chk(cmd_now() == 4'b0001 && !sd_cke, "R2 refresh with cke low", {sd_cke, cmd_now()}, 4'b0001);
    for (int i = 0; i < 8; i++) begin
      cyc();
      chk(cmd_now() == 4'b0111 && !sd_cke, "R2 self-refresh hold", {sd_cke, cmd_now()}, 4'b0111);
    end
    if (by_enable) cfg_ref_en = 1'b0; else cfg_ref_self = 1'b0;
    cyc();
    while (!sd_ready && n < 20) begin
      chk(sd_cke, "R9 cke high during exit", sd_cke, 1);
      n++;
      cyc();
    end
    chk(n == EXIT_CYC, "R9 exit wait length", n, EXIT_CYC);
    cfg_ref_en = 1'b0; cfg_ref_self = 1'b0;
    repeat (6) cyc();
  endtask

  initial begin
    #(8 * 150000);
    errs++; checks++;
    $display("FAIL watchdog all-R act=timeout exp=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int m;
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    cfg_halfcyc_hold = 1'b0; cfg_ref_en = 1'b0; cfg_ref_self = 1'b0; cfg_pd_en = 1'b0;
    ref_cmp = '0; bus_act = 1'b0; bus_sdram = 1'b0; bus_end = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (4) cyc();

    // R7 reset state
    chk(sd_cke, "R7 cke after reset", sd_cke, 1);
    chk(cmd_now() == 4'b0111, "R7 NOP after reset", cmd_now(), 4'b0111);
    chk(sd_ready, "R7 ready after reset", sd_ready, 1);
    chk(!launch_fall && !capture_fall, "R7 edge selects", {launch_fall, capture_fall}, 0);

    // R1 refresh disabled, random traffic and mode bit
    for (int i = 0; i < 40; i++) begin
      cfg_ref_self = 1'($urandom % 2);
      bus_act = 1'($urandom % 2);
      bus_sdram = 1'($urandom % 2);
      bus_end = bus_act & 1'($urandom % 2);
      cyc();
      chk(cmd_now() == 4'b0111, "R1 no refresh when disabled", cmd_now(), 4'b0111);
    end
    bus_act = 0; bus_sdram = 0; bus_end = 0; cfg_ref_self = 0;
    repeat (4) cyc();

    // R3 auto-refresh intervals
    ref_gaps(10, 60);
    ref_gaps(8 + int'($urandom % 12), 90);

    // R10 refresh blocked by an SDRAM access
    ref_cmp = CNT_W'(10); cfg_ref_en = 1'b1; bus_act = 1'b1; bus_sdram = 1'b1;
    for (int i = 0; i < 30; i++) begin
      cyc();
      chk(cmd_now() != 4'b0001, "R10 no refresh during access", cmd_now(), 4'b0111);
    end
    bus_act = 1'b0; bus_sdram = 1'b0;
    cyc();
    chk(cmd_now() == 4'b0001, "R10 refresh right after access", cmd_now(), 4'b0001);
    cfg_ref_en = 1'b0;
    repeat (8) cyc();

    // R2 and R9 via both exit causes
    self_exit(1'b0);
    self_exit(1'b1);

    // R4 power-down after non-SDRAM access, R8 wake by SDRAM request
    cfg_pd_en = 1'b1; bus_act = 1'b1; bus_sdram = 1'b0;
    cyc(); cyc();
    chk(sd_cke, "R4 cke high during access", sd_cke, 1);
    bus_end = 1'b1;
    cyc();
    bus_act = 1'b0; bus_end = 1'b0;
    cyc();
    chk(!sd_cke && !sd_ready, "R4 power-down entered", {sd_cke, sd_ready}, 0);
    repeat (4) cyc();
    chk(!sd_cke, "R4 power-down held", sd_cke, 0);
    bus_act = 1'b1; bus_sdram = 1'b1;
    cyc();
    chk(sd_cke && !sd_ready, "R8 cke up before ready", {sd_cke, sd_ready}, 2);
    cyc();
    chk(sd_ready && sd_cke, "R8 ready after wake", {sd_cke, sd_ready}, 3);
    cyc(); bus_end = 1'b1;
    cyc(); bus_end = 1'b0; bus_act = 1'b0; bus_sdram = 1'b0;
    cyc();
    chk(sd_cke, "R4 SDRAM access does not power down", sd_cke, 1);

    // R8 wake by clearing power-down enable
    bus_act = 1'b1; bus_end = 1'b1;
    cyc(); bus_act = 1'b0; bus_end = 1'b0;
    cyc();
    chk(!sd_cke, "R4 second power-down", sd_cke, 0);
    cfg_pd_en = 1'b0;
    cyc();
    chk(sd_cke && !sd_ready, "R8 wake on enable cleared", {sd_cke, sd_ready}, 2);
    cyc();
    chk(sd_ready, "R8 ready after enable cleared", sd_ready, 1);

    // R5 no power-down when disabled
    bus_act = 1'b1; bus_end = 1'b1;
    cyc(); bus_act = 1'b0; bus_end = 1'b0;
    for (int i = 0; i < 5; i++) begin
      cyc();
      chk(sd_cke, "R5 cke stays high", sd_cke, 1);
    end

    // R6 edge select directed
    cfg_halfcyc_hold = 1'b1;
    cyc();
    chk(launch_fall && capture_fall, "R6 falling edge selected", {launch_fall, capture_fall}, 3);
    cfg_halfcyc_hold = 1'b0;
    cyc();
    chk(!launch_fall && !capture_fall, "R6 rising edge selected", {launch_fall, capture_fall}, 0);

    // random phase: R4 R5 R6 R8 against bench model
    m = 0;
    bus_act = 1'b1; bus_sdram = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 8 == 0) cfg_pd_en = ~cfg_pd_en;
      cfg_halfcyc_hold = 1'($urandom % 2);
      bus_end = ($urandom % 4 == 0);
      m = pd_next(m, cfg_pd_en, bus_end);
      cyc();
      chk(sd_cke == (m != 1), "R4/R5 random cke", sd_cke, int'(m != 1));
      chk(sd_ready == (m == 0), "R8 random ready", sd_ready, int'(m == 0));
      chk(launch_fall == cfg_halfcyc_hold, "R6 random edge", launch_fall, cfg_halfcyc_hold);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule